// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the digital slave side of a two-wire serial memory that holds 2048 bytes. It oversamples the SCL and SDA lines with the system clock, and it detects START and STOP conditions. It checks the device-type nibble of the address byte and then either takes a word address and write data, or shifts stored bytes out to the master. SDA is open-drain: the block has one output enable that pulls the line low, and it never drives a high level.

Write data goes first into a 16-byte page buffer. The buffered bytes are stored in the array only when a STOP arrives. That STOP also starts a self-timed internal write cycle. While the cycle runs, the block refuses its device address, so a host can poll for completion by sending START and the device address until it receives an ACK. A write-protect input makes the array read only. When it is set, the address bytes are still acknowledged, but the first data byte is refused. Reads use an internal address counter, and there are three kinds: current-address, random (a dummy write of the word address followed by a repeated START) and sequential.

The controller is built around one state machine with these states:
- ST_IDLE: waits for a START.
- ST_DEVADR: shifts in the device byte.
- ST_DEVACK: the device-byte ACK slot.
- ST_WADR: shifts in the word address.
- ST_WADRACK: the word-address ACK slot.
- ST_WDATA: shifts in a data byte.
- ST_WDACK: the data ACK slot.
- ST_RDATA: shifts out a read byte.
- ST_RDACK: the master's acknowledge slot.

A START moves any state to ST_DEVADR, and a STOP moves any state to ST_IDLE. All other transitions happen on a falling SCL edge:
- ST_DEVADR goes to ST_DEVACK when the byte matches and no write cycle is busy. Otherwise it goes to ST_IDLE.
- ST_DEVACK goes to ST_RDATA for a read and to ST_WADR for a write.
- ST_WADR goes to ST_WADRACK, and ST_WADRACK goes to ST_WDATA.
- ST_WDATA goes to ST_WDACK, or to ST_IDLE when write protect is set.
- ST_WDACK goes back to ST_WDATA.
- ST_RDATA goes to ST_RDACK after 8 bits.
- ST_RDACK goes to ST_RDATA when the master acknowledges, and to ST_IDLE when it does not.

Top module: `ee2w_slave`

## Requirements
- R1: A device byte whose bits 7:4 are not 1010 gets no ACK. The block then ignores the bus until the next START, and the address counter is left unchanged.
- R2: In a write, bits 3:1 of the device byte give word-address bits 10:8, and the next byte gives bits 7:0. Bit 0 of the device byte is the R/W bit (0 = write, 1 = read). The device byte, the word address and each data byte are acknowledged.
- R3: Within one write, data bytes fill a 16-byte page. The low 4 address bits wrap inside the page, so the write after offset 15 lands at offset 0. Bytes reach the array only at STOP. A START that comes before the STOP discards them.
- R4: A STOP after at least one accepted data byte starts an internal write cycle of WR_CYCLES clocks. While it runs, the device byte gets no ACK in either direction. Once it ends, the device byte is acknowledged again.
- R5: While write protect is high, the device byte and the word address are acknowledged. The first data byte gets no ACK, the array is not changed, and no write cycle starts.
- R6: The address counter holds the last accessed address plus one, modulo 2048. A word address loads the counter, and a current-address read returns the byte at the counter.
- R7: A random read (a dummy write of the word address, then a repeated START and a read) returns the byte at that word address.
- R8: In a sequential read, each master ACK produces the next byte. After address 2047 the read continues at address 0.
- R9: Read data is sent MSB first, and the SDA enable changes only while SCL is low. SDA is released outside ACK slots and read data bits. A master NACK followed by STOP ends the read with SDA released.
- R10: After reset, SDA is released, the array reads as zero, the counter is 0 and no write cycle is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| wp_i | input | 1 | Write protect; high makes the array read only |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench uses WR_CYCLES = 400, with the default 2048-byte array and 16-byte page. With a cycle this short, each write ends in a handful of polls: the first poll is refused, and a later one is accepted once at least 400 clocks have passed since the STOP. The bench can therefore check both the refusal and the length of the cycle. The full-size array keeps the page roll at 0x7F0–0x7FF and the counter wrap from 2047 to 0 on the real boundaries.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_WADR,
        ST_WADRACK,
        ST_WDATA,
        ST_WDACK,
        ST_RDATA,
        ST_RDACK
    } ee_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

endpackage

// File: rtl/ee2w_lines.sv
module ee2w_lines #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_p;
    logic                   sda_p;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/ee2w_wtimer.sv
module ee2w_wtimer #(
    parameter int WR_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(WR_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - ONE;
        end
    end

    assign busy = (left_q != '0);

    // R4: a write cycle only ever begins from a start request
    assert_cycle_from_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/ee2w_store.sv
module ee2w_store #(
    parameter int MEM_BYTES  = 2048,
    parameter int PAGE_BYTES = 16
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           pg_wr,
    input  logic [$clog2(PAGE_BYTES)-1:0]                  pg_idx,
    input  logic [7:0]                                     pg_data,
    input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] pg_base,
    input  logic                                           pg_clear,
    input  logic                                           commit,
    input  logic [$clog2(MEM_BYTES)-1:0]                   rd_addr,
    output logic [7:0]                                     rd_data,
    output logic                                           pend
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - PAGE_W;

    logic [7:0]            mem   [MEM_BYTES];
    logic [7:0]            buf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;
    logic [BASE_W-1:0]     base_q;
    logic                  commit_go;

    assign pend      = |valid_q;
    assign commit_go = commit & pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            base_q  <= '0;
            for (int j = 0; j < PAGE_BYTES; j++) buf_q[j] <= '0;
        end else if (pg_clear || commit) begin
            valid_q <= '0;
        end else if (pg_wr) begin
            buf_q[pg_idx]   <= pg_data;
            valid_q[pg_idx] <= 1'b1;
            base_q          <= pg_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
        end else if (commit_go) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (valid_q[j]) mem[{base_q, PAGE_W'(j)}] <= buf_q[j];
            end
        end
    end

    assign rd_data = mem[rd_addr];

    // R3: after the buffer is written to the array nothing stays pending
    assert_buffer_drained_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |=> !pend);

endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter int MEM_BYTES   = 2048,
    parameter int PAGE_BYTES  = 16,
    parameter int WR_CYCLES   = 20000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int HI_W   = ADDR_W - 8;
    localparam int BASE_W = ADDR_W - PAGE_W;
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
    localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);
    localparam logic [3:0]        ONE_C = 4'd1;

    ee_state_t         state, nstate;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              busy, pend;
    logic [3:0]        bit_cnt;
    logic [7:0]        sh_q;
    logic [7:0]        rd_sh;
    logic [7:0]        rd_data;
    logic              rw_q;
    logic              mack_q;
    logic [HI_W-1:0]   blk_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PAGE_W-1:0] page_ptr;
    logic [BASE_W-1:0] pg_hi_q;
    logic [ADDR_W-1:0] word_addr;
    logic              byte_done;
    logic              dev_match;
    logic              pg_wr;

    ee2w_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ee2w_wtimer #(.WR_CYCLES(WR_CYCLES)) u_wtimer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (stop_det & pend),
        .busy  (busy)
    );

    ee2w_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .pg_wr    (pg_wr),
        .pg_idx   (page_ptr),
        .pg_data  (sh_q),
        .pg_base  (pg_hi_q),
        .pg_clear (start_det),
        .commit   (stop_det),
        .rd_addr  (addr_q),
        .rd_data  (rd_data),
        .pend     (pend)
    );

    assign byte_done = (bit_cnt == BITS_PER_BYTE);
    assign dev_match = (sh_q[7:4] == DEV_TYPE) && !busy;
    assign word_addr = {blk_q, sh_q};
    assign pg_wr     = scl_fall && !start_det && !stop_det &&
                       (state == ST_WDATA) && byte_done && !wp_i;

    // next-state decision
    always_comb begin
        nstate = state;
        if (start_det) begin
            nstate = ST_DEVADR;
        end else if (stop_det) begin
            nstate = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:    nstate = ST_IDLE;
                ST_DEVADR:  if (byte_done) nstate = dev_match ? ST_DEVACK : ST_IDLE;
                ST_DEVACK:  nstate = rw_q ? ST_RDATA : ST_WADR;
                ST_WADR:    if (byte_done) nstate = ST_WADRACK;
                ST_WADRACK: nstate = ST_WDATA;
                ST_WDATA:   if (byte_done) nstate = wp_i ? ST_IDLE : ST_WDACK;
                ST_WDACK:   nstate = ST_WDATA;
                ST_RDATA:   if (byte_done) nstate = ST_RDACK;
                ST_RDACK:   nstate = mack_q ? ST_RDATA : ST_IDLE;
                default:    nstate = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // shift registers, counters and address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            sh_q     <= '0;
            rd_sh    <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            blk_q    <= '0;
            addr_q   <= '0;
            page_ptr <= '0;
            pg_hi_q  <= '0;
        end else if (start_det) begin
            bit_cnt <= '0;
        end else if (!stop_det) begin
            if (scl_rise) begin
                unique case (state)
                    ST_DEVADR, ST_WADR, ST_WDATA: begin
                        sh_q    <= {sh_q[6:0], sda_s};
                        bit_cnt <= bit_cnt + ONE_C;
                    end
                    ST_RDATA: bit_cnt <= bit_cnt + ONE_C;
                    ST_RDACK: mack_q  <= !sda_s;
                    default: ;
                endcase
            end
            if (scl_fall) begin
                unique case (state)
                    ST_DEVADR: begin
                        if (byte_done && dev_match) begin
                            rw_q  <= sh_q[0];
                            blk_q <= sh_q[HI_W:1];
                        end
                    end
                    ST_DEVACK: begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            rd_sh  <= rd_data;
                            addr_q <= addr_q + ONE_A;
                        end
                    end
                    ST_WADR: begin
                        if (byte_done) begin
                            addr_q   <= word_addr;
                            page_ptr <= word_addr[PAGE_W-1:0];
                            pg_hi_q  <= word_addr[ADDR_W-1:PAGE_W];
                        end
                    end
                    ST_WADRACK, ST_WDACK: bit_cnt <= '0;
                    ST_WDATA: begin
                        if (byte_done && !wp_i) begin
                            addr_q   <= {pg_hi_q, page_ptr} + ONE_A;
                            page_ptr <= page_ptr + ONE_P;
                        end
                    end
                    ST_RDATA: begin
                        if (!byte_done) rd_sh <= {rd_sh[6:0], 1'b0};
                    end
                    ST_RDACK: begin
                        if (mack_q) begin
                            rd_sh   <= rd_data;
                            addr_q  <= addr_q + ONE_A;
                            bit_cnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // open-drain output: ACK slots and read data bits only
    always_comb begin
        unique case (state)
            ST_DEVACK, ST_WADRACK, ST_WDACK: sda_oe = 1'b1;
            ST_RDATA:                        sda_oe = ~rd_sh[7];
            default:                         sda_oe = 1'b0;
        endcase
    end

    // R9: the pull-down only changes while the sampled clock line is low
    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R4: no device acknowledge while the write cycle is running
    assert_nack_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEVACK) |-> !busy);

    // R5: a data ACK slot is never entered with write protect set
    assert_wp_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WDACK) && ($past(state) != ST_WDACK)) |-> !$past(wp_i));

endmodule

// File: tb/test_ee2w_slave.sv
module test_ee2w_slave;
    localparam int WRC = 400;
    localparam int Q   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    logic [7:0] mdl [2048];
    int mcnt = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign sda_bus = sda_drv & ~sda_oe;

    ee2w_slave #(.WR_CYCLES(WRC)) i_ee2w_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_byte(input int a, input logic rd);
        logic [10:0] av;
        av = 11'(a);
        return {4'b1010, av[10:8], rd};
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq(); scl = 1'b1; wq(); sda_drv = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(); scl = 1'b1; wq(); sda_drv = 1'b1; wq();
    endtask

    task automatic bit_out(input logic b);
        sda_drv = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    endtask

    task automatic bit_in(output logic b, output logic stable);
        logic first;
        sda_drv = 1'b1; wq(); scl = 1'b1;
        @(negedge clk); first = sda_bus;
        wq(); b = sda_bus;
        repeat (Q - 1) @(negedge clk);
        stable = (first == sda_bus);
        scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b, st;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b, st);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack, output logic stable);
        logic b, st;
        stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b, st);
            d[i] = b;
            stable &= st;
        end
        bit_out(!mack);
    endtask

    // acknowledge polling until the write cycle ends
    task automatic poll_done(input int t_stop);
        logic ack;
        int tries = 0;
        ack = 1'b0;
        while (!ack && tries < 40) begin
            bus_start();
            send_byte(dev_byte(0, 1'b0), ack);
            if (tries == 0) chk("R4 first poll refused", int'(ack), 0);
            bus_stop();
            tries++;
        end
        chk("R4 poll finally acknowledged", int'(ack), 1);
        chk("R4 cycle not shorter than WR_CYCLES", int'((cyc - t_stop) >= WRC), 1);
    endtask

    task automatic wr_page(input int a, input int n);
        logic ack;
        logic [7:0] pd [16];
        logic pv [16];
        int p, hi;
        logic [7:0] d;
        for (int j = 0; j < 16; j++) pv[j] = 1'b0;
        p  = a & 15;
        hi = a & 2032;
        bus_start();
        send_byte(dev_byte(a, 1'b0), ack); chk("R2 device byte ack", int'(ack), 1);
        send_byte(8'(a), ack);             chk("R2 word address ack", int'(ack), 1);
        mcnt = a;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ack); chk("R2 data byte ack", int'(ack), 1);
            pd[p] = d; pv[p] = 1'b1;
            mcnt = ((hi | p) + 1) & 2047;
            p = (p + 1) & 15;
        end
        bus_stop();
        for (int j = 0; j < 16; j++) if (pv[j]) mdl[hi | j] = pd[j];
        if (n > 0) poll_done(cyc);
    endtask

    task automatic rd_cur(input int n, input string tag);
        logic ack, st;
        logic [7:0] d;
        bus_start();
        send_byte(dev_byte(0, 1'b1), ack); chk({tag, " read device ack"}, int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(d, i < n - 1, st);
            chk({tag, " read data"}, int'(d), int'(mdl[mcnt]));
            chk("R9 data stable while SCL high", int'(st), 1);
            mcnt = (mcnt + 1) & 2047;
        end
        bus_stop();
        chk("R9 SDA released after read", int'(sda_oe), 0);
    endtask

    task automatic rd_rand(input int a, input int n, input string tag);
        logic ack;
        bus_start();
        send_byte(dev_byte(a, 1'b0), ack); chk("R7 dummy write device ack", int'(ack), 1);
        send_byte(8'(a), ack);             chk("R7 dummy write word ack", int'(ack), 1);
        mcnt = a;
        rd_cur(n, tag);
    endtask

    task automatic wr_protected(input int a);
        logic ack;
        wp = 1'b1;
        bus_start();
        send_byte(dev_byte(a, 1'b0), ack); chk("R5 device ack under WP", int'(ack), 1);
        send_byte(8'(a), ack);             chk("R5 word ack under WP", int'(ack), 1);
        send_byte(~mdl[a], ack);           chk("R5 first data byte refused", int'(ack), 0);
        bus_stop();
        wp = 1'b0;
        mcnt = a;
        bus_start();
        send_byte(dev_byte(0, 1'b0), ack); chk("R5 no write cycle started", int'(ack), 1);
        bus_stop();
        rd_cur(1, "R5 array unchanged");
    endtask

    initial begin : main
        logic ack;
        void'($urandom(32'd4242));
        for (int i = 0; i < 2048; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 SDA released after reset", int'(sda_oe), 0);
        rd_cur(2, "R10 zero array from address 0");

        // wrong device type is ignored, counter untouched
        bus_start();
        send_byte(8'b1011_0001, ack); chk("R1 wrong device type refused", int'(ack), 0);
        bus_stop();
        rd_cur(1, "R1 counter unaffected");

        // page roll at the top page, then read across the wrap
        wr_page(2046, 4);
        rd_cur(1, "R6 counter after write");
        rd_rand(2046, 4, "R8 sequential wrap");
        rd_rand(2032, 2, "R3 page roll landed at offset 0");

        // discard on START before STOP
        bus_start();
        send_byte(dev_byte(300, 1'b0), ack); chk("R2 device byte ack", int'(ack), 1);
        send_byte(8'(300), ack);             chk("R2 word address ack", int'(ack), 1);
        send_byte(~mdl[300], ack);           chk("R2 data byte ack", int'(ack), 1);
        mcnt = 301;
        rd_cur(1, "R3 discarded write leaves counter");
        rd_rand(300, 1, "R3 discarded write not stored");

        wr_protected(500);

        // random mix
        for (int k = 0; k < 20; k++) begin
            int op, a, n;
            op = int'($urandom % 4);
            a  = int'($urandom % 2048);
            n  = 1 + int'($urandom % 18);
            case (op)
                0: wr_page(a, n);
                1: rd_cur(1 + n % 4, "R6 current read");
                2: rd_rand(a, 1 + n % 4, "R7 random read");
                default: wr_protected(a);
            endcase
        end

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule